// File: doc/BRIEF.md
# Indexed Register Port for a Display Controller

This block is the host-side register file of a display controller. A host reaches it over a 16-bit parallel bus that has a single data/command select line. A write in command phase picks a register address. Data-phase writes and reads then reach the register at that address. After each data access the address steps on to the next register. The exception is a streaming port, where the address stays fixed so that a burst of accesses lands on the same port.

The block stores the controller's configuration. Each register has its own write mask and its own reset value. Some wide fields are split across a pair of byte registers. A few registers return fixed or encoded values on readback. Two lookup tables are reached through an index register and a data port whose index advances by itself: a 32-entry filter coefficient table and a 256-entry gamma table. There is also a GPIO interrupt status register that hardware sets and the host clears by writing. The rest of the chip reads the stored values through the output ports and the table lookup ports. A write to the pixel port is passed straight out as a strobe.

Top module: `disp_regport`

## Requirements
- R1: A write with `bus_dc_i` low loads the register address from `bus_wdata_i[7:0]`. A read with `bus_dc_i` low returns the current address on `bus_rdata_o[7:0]`, with the upper bits zero.
- R2: After each data-phase access the address advances by 2, wrapping at 8 bits. It stays unchanged when the address is 0x90 (pixel port), 0x5A (filter data port) or 0xB8 (gamma data port).
- R3: A data-phase read puts the value at the current address on `bus_rdata_o` in the cycle after the read strobe. A write takes priority over a read in the same cycle. Unmapped addresses read as 0 and ignore writes.
- R4: The filter index register at 0x58 keeps only `wdata[4:0]`. Each access to 0x5A reads or writes the entry at that index and then increments the index. Once the index reaches 32, accesses have no effect, reads return 0, and 0x58 reads back 32.
- R5: The gamma index register at 0xB6 keeps 8 bits. Each access to 0xB8 reads or writes the entry at that index and then increments the index, wrapping from 255 to 0.
- R6: A write to 0x04 stores `(wdata & 0x3F) + 1` as the divider, which is driven on `pll_div_o`. A read of 0x04 returns the stored value minus 1 with bit 7 set. The divider resets to 1.
- R7: Window coordinates are 10 bits wide. X start is at 0x6C/0x6E, Y start at 0x70/0x72, X end at 0x74/0x76 and Y end at 0x78/0x7A. The low register of each pair holds bits 7:0 and the high register holds bits 9:8. The refresh interval is 12 bits at 0x18/0x1A, with the high register holding bits 11:8, and resets to 0x25C. A read of either register in a pair returns its own slice of the field.
- R8: A write to 0xF6 ANDs `wdata[7:0]` into the interrupt status. A set bit in `gpio_evt_i` sets the matching status bit, and a set wins over a clear in the same cycle.
- R9: The colour matrix has 18 coefficients at 0xBC..0xDE. The coefficient at address a is entry (a-0xBC)/2, driven on `matrix_coeff_o[8k+7:8k]`. A write to an address with bit 1 set keeps only bit 7. Other coefficient addresses keep all 8 bits.
- R10: Address 0x02 always reads 0x83. Address 0xE8 stores `wdata & 0x1B` and reads back the stored value with bit 5 set.
- R11: Reset values are: 0x28 = 0x74, 0x42 = 0x01 (write mask 0xBD), 0x56 = 0x80 (write mask 0xBF), 0xF8 = 0xFF. All matrix coefficients, both edge enables (0xF2, 0xF4) and the interrupt status reset to 0.
- R12: A data write to 0x90 raises `pix_wr_o` in the same cycle, with `pix_data_o` carrying the full 16-bit value. A read of 0x90 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_i | input | 1 | Bus write strobe |
| bus_rd_i | input | 1 | Bus read strobe |
| bus_dc_i | input | 1 | 1 = data phase, 0 = command phase |
| bus_wdata_i | input | 16 | Bus write value |
| bus_rdata_o | output | 16 | Registered read value |
| gpio_evt_i | input | 8 | Interrupt set pulses |
| filt_lu_addr_i | input | 5 | Filter table lookup address |
| filt_lu_data_o | output | 8 | Filter table lookup data |
| gamma_lu_addr_i | input | 8 | Gamma table lookup address |
| gamma_lu_data_o | output | 8 | Gamma table lookup data |
| pll_div_o | output | 7 | Stored divider, 1..64 |
| refresh_o | output | 12 | Refresh interval |
| lcd_cfg_o | output | 8 | Panel configuration |
| tx_mode_o | output | 8 | Serial transmit mode |
| filt_cfg_o | output | 8 | Filter configuration |
| nd_ctrl_o | output | 8 | Non-display control |
| win_x0_o | output | 10 | Window X start |
| win_y0_o | output | 10 | Window Y start |
| win_x1_o | output | 10 | Window X end |
| win_y1_o | output | 10 | Window Y end |
| matrix_coeff_o | output | 144 | 18 packed colour matrix coefficients |
| gpio_pos_en_o | output | 8 | Rising-edge interrupt enables |
| gpio_neg_en_o | output | 8 | Falling-edge interrupt enables |
| gpio_pdown_o | output | 8 | Pull-down control |
| gpio_irq_o | output | 8 | Interrupt status |
| pix_wr_o | output | 1 | Pixel port write strobe |
| pix_data_o | output | 16 | Pixel port write data |

## Verification
The assertions check the following on every cycle:
- how the address moves after command loads, ordinary data accesses and streaming-port accesses;
- that read data is captured;
- that the filter index stays bounded and holds once it reaches 32;
- the one-step advance of each table index;
- the legal range of the divider;
- the AND-clear and set-priority rules of the interrupt status.

Other behaviour can only be shown by the bench's scenarios:
- the encoded readbacks and write masks;
- the placement of split fields;
- coefficient truncation by address;
- reset values;
- which table entry a burst actually lands in.

// File: rtl/disp_regport_pkg.sv
package disp_regport_pkg;
    localparam int BUS_W = 16;
    localparam int ADDR_W = 8;
    typedef logic [ADDR_W-1:0] addr_t;

    localparam addr_t A_CFG_RB   = 8'h02;
    localparam addr_t A_PLL      = 8'h04;
    localparam addr_t A_REF_LO   = 8'h18;
    localparam addr_t A_REF_HI   = 8'h1A;
    localparam addr_t A_LCD      = 8'h28;
    localparam addr_t A_TXMODE   = 8'h42;
    localparam addr_t A_FCFG     = 8'h56;
    localparam addr_t A_FIDX     = 8'h58;
    localparam addr_t A_FDATA    = 8'h5A;
    localparam addr_t A_WIN_BASE = 8'h6C;
    localparam addr_t A_PIXEL    = 8'h90;
    localparam addr_t A_GIDX     = 8'hB6;
    localparam addr_t A_GDATA    = 8'hB8;
    localparam addr_t A_MAT_BASE = 8'hBC;
    localparam addr_t A_ND       = 8'hE8;
    localparam addr_t A_EPOS     = 8'hF2;
    localparam addr_t A_ENEG     = 8'hF4;
    localparam addr_t A_IRQ      = 8'hF6;
    localparam addr_t A_PDOWN    = 8'hF8;

    function automatic logic is_stream(addr_t a);
        return (a == A_PIXEL) || (a == A_FDATA) || (a == A_GDATA);
    endfunction
endpackage

// File: rtl/disp_regport_bus.sv
module disp_regport_bus
    import disp_regport_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic             rd_i,
    input  logic             dc_i,
    input  logic [7:0]       wdata_i,
    input  logic [BUS_W-1:0] rd_val_i,
    output addr_t            addr_o,
    output logic             data_wr_o,
    output logic             data_rd_o,
    output logic [BUS_W-1:0] rdata_o
);
    typedef struct packed {
        addr_t            idx;
        logic [BUS_W-1:0] rdata;
    } bus_s;

    bus_s st_d, st_q;
    logic cmd_wr, cmd_rd, data_acc;

    assign cmd_wr    = wr_i && !dc_i;
    assign data_wr_o = wr_i && dc_i;
    assign data_rd_o = rd_i && !wr_i && dc_i;
    assign cmd_rd    = rd_i && !wr_i && !dc_i;
    assign data_acc  = data_wr_o || data_rd_o;

    always_comb begin
        st_d = st_q;
        if (cmd_wr)
            st_d.idx = wdata_i;
        else if (data_acc && !is_stream(st_q.idx))
            st_d.idx = st_q.idx + addr_t'(2);
        if (data_rd_o)
            st_d.rdata = rd_val_i;
        else if (cmd_rd)
            st_d.rdata = BUS_W'(st_q.idx);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr_o  = st_q.idx;
    assign rdata_o = st_q.rdata;

    // R1: a command write loads the address
    a_r1_cmd_load: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |=> addr_o == $past(wdata_i));
    // R2: ordinary data access steps the address by two
    a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && !is_stream(addr_o)) |=> addr_o == $past(addr_o) + addr_t'(2));
    // R2: streaming ports hold the address
    a_r2_stream_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && is_stream(addr_o)) |=> $stable(addr_o));
    // R3: read value captured one cycle after the strobe
    a_r3_rd_capture: assert property (@(posedge clk) disable iff (!rst_n)
        data_rd_o |=> rdata_o == $past(rd_val_i));
endmodule

// File: rtl/disp_regport_table.sv
module disp_regport_table #(
    parameter int DEPTH    = 32,
    parameter bit SATURATE = 1'b1,
    localparam int LW = $clog2(DEPTH),
    localparam int IW = SATURATE ? LW + 1 : LW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          idx_wr_i,
    input  logic [IW-1:0] idx_val_i,
    input  logic          acc_wr_i,
    input  logic          acc_rd_i,
    input  logic [7:0]    wdata_i,
    output logic [IW-1:0] idx_o,
    output logic [7:0]    rdata_o,
    input  logic [LW-1:0] lu_addr_i,
    output logic [7:0]    lu_data_o
);
    typedef struct packed {
        logic [IW-1:0]          idx;
        logic [DEPTH-1:0][7:0]  mem;
    } tab_s;

    tab_s st_d, st_q;
    logic in_range;
    logic acc;

    assign acc = acc_wr_i || acc_rd_i;

    generate
        if (SATURATE) begin : g_sat
            assign in_range = (32'(st_q.idx) < DEPTH);
        end else begin : g_wrap
            assign in_range = 1'b1;
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (idx_wr_i)
            st_d.idx = idx_val_i;
        else if (acc && in_range) begin
            if (acc_wr_i)
                st_d.mem[st_q.idx[LW-1:0]] = wdata_i;
            st_d.idx = st_q.idx + IW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign idx_o     = st_q.idx;
    assign rdata_o   = in_range ? st_q.mem[st_q.idx[LW-1:0]] : 8'h00;
    assign lu_data_o = st_q.mem[lu_addr_i];

    // R4/R5: an effective access moves the index by exactly one
    a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && in_range && !idx_wr_i) |=> idx_o == $past(idx_o) + IW'(1));

    generate
        if (SATURATE) begin : g_sat_chk
            // R4: index never passes the table end
            a_r4_bound: assert property (@(posedge clk) disable iff (!rst_n)
                32'(idx_o) <= DEPTH);
            // R4: accesses beyond the end leave the index alone
            a_r4_hold_end: assert property (@(posedge clk) disable iff (!rst_n)
                (acc && !in_range && !idx_wr_i) |=> $stable(idx_o));
        end
    endgenerate
endmodule

// File: rtl/disp_regport_cfg.sv
module disp_regport_cfg
    import disp_regport_pkg::*;
#(
    parameter int COORD_W = 10,
    parameter int REF_W   = 12,
    parameter int MAT_N   = 18,
    parameter int N_WIN   = 4,
    parameter int GPIO_W  = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_i,
    input  addr_t                  addr_i,
    input  logic [7:0]             wdata_i,
    input  logic [GPIO_W-1:0]      evt_i,
    output logic [BUS_W-1:0]       rd_val_o,
    output logic [6:0]             pll_o,
    output logic [REF_W-1:0]       refresh_o,
    output logic [7:0]             lcd_o,
    output logic [7:0]             txm_o,
    output logic [7:0]             fcfg_o,
    output logic [7:0]             nd_o,
    output logic [N_WIN-1:0][COORD_W-1:0] win_o,
    output logic [MAT_N-1:0][7:0]  mat_o,
    output logic [GPIO_W-1:0]      epos_o,
    output logic [GPIO_W-1:0]      eneg_o,
    output logic [GPIO_W-1:0]      pdown_o,
    output logic [GPIO_W-1:0]      irq_o
);
    localparam int CH = COORD_W - 8;
    localparam int RH = REF_W - 8;

    typedef struct packed {
        logic [6:0]                   pll;
        logic [REF_W-1:0]             refresh;
        logic [7:0]                   lcd;
        logic [7:0]                   txm;
        logic [7:0]                   fcfg;
        logic [7:0]                   nd;
        logic [N_WIN-1:0][COORD_W-1:0] win;
        logic [MAT_N-1:0][7:0]        mat;
        logic [GPIO_W-1:0]            epos;
        logic [GPIO_W-1:0]            eneg;
        logic [GPIO_W-1:0]            pdown;
        logic [GPIO_W-1:0]            irq;
    } cfg_s;

    localparam cfg_s CFG_RST = '{
        pll: 7'd1, refresh: REF_W'(12'h25C), lcd: 8'h74, txm: 8'h01,
        fcfg: 8'h80, nd: 8'h00, win: '0, mat: '0, epos: '0, eneg: '0,
        pdown: '1, irq: '0};

    cfg_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            case (addr_i)
                A_PLL:    st_d.pll = {1'b0, wdata_i[5:0]} + 7'd1;
                A_REF_LO: st_d.refresh[7:0] = wdata_i;
                A_REF_HI: st_d.refresh[REF_W-1:8] = wdata_i[RH-1:0];
                A_LCD:    st_d.lcd = wdata_i;
                A_TXMODE: st_d.txm = wdata_i & 8'hBD;
                A_FCFG:   st_d.fcfg = wdata_i & 8'hBF;
                A_ND:     st_d.nd = wdata_i & 8'h1B;
                A_EPOS:   st_d.epos = wdata_i[GPIO_W-1:0];
                A_ENEG:   st_d.eneg = wdata_i[GPIO_W-1:0];
                A_PDOWN:  st_d.pdown = wdata_i[GPIO_W-1:0];
                A_IRQ:    st_d.irq = st_q.irq & wdata_i[GPIO_W-1:0];
                default: ;
            endcase
            for (int k = 0; k < N_WIN; k++) begin
                if (addr_i == A_WIN_BASE + addr_t'(4 * k))
                    st_d.win[k][7:0] = wdata_i;
                if (addr_i == A_WIN_BASE + addr_t'(4 * k + 2))
                    st_d.win[k][COORD_W-1:8] = wdata_i[CH-1:0];
            end
            for (int k = 0; k < MAT_N; k++) begin
                if (addr_i == A_MAT_BASE + addr_t'(2 * k))
                    st_d.mat[k] = wdata_i & (addr_i[1] ? 8'h80 : 8'hFF);
            end
        end
        st_d.irq = st_d.irq | evt_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= CFG_RST;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_val_o = '0;
        case (addr_i)
            A_CFG_RB: rd_val_o = 16'h0083;
            A_PLL:    rd_val_o = 16'h0080 | BUS_W'(st_q.pll - 7'd1);
            A_REF_LO: rd_val_o = BUS_W'(st_q.refresh[7:0]);
            A_REF_HI: rd_val_o = BUS_W'(st_q.refresh[REF_W-1:8]);
            A_LCD:    rd_val_o = BUS_W'(st_q.lcd);
            A_TXMODE: rd_val_o = BUS_W'(st_q.txm);
            A_FCFG:   rd_val_o = BUS_W'(st_q.fcfg);
            A_ND:     rd_val_o = BUS_W'(st_q.nd | 8'h20);
            A_EPOS:   rd_val_o = BUS_W'(st_q.epos);
            A_ENEG:   rd_val_o = BUS_W'(st_q.eneg);
            A_PDOWN:  rd_val_o = BUS_W'(st_q.pdown);
            A_IRQ:    rd_val_o = BUS_W'(st_q.irq);
            default: ;
        endcase
        for (int k = 0; k < N_WIN; k++) begin
            if (addr_i == A_WIN_BASE + addr_t'(4 * k))
                rd_val_o = BUS_W'(st_q.win[k][7:0]);
            if (addr_i == A_WIN_BASE + addr_t'(4 * k + 2))
                rd_val_o = BUS_W'(st_q.win[k][COORD_W-1:8]);
        end
        for (int k = 0; k < MAT_N; k++) begin
            if (addr_i == A_MAT_BASE + addr_t'(2 * k))
                rd_val_o = BUS_W'(st_q.mat[k]);
        end
    end

    assign pll_o     = st_q.pll;
    assign refresh_o = st_q.refresh;
    assign lcd_o     = st_q.lcd;
    assign txm_o     = st_q.txm;
    assign fcfg_o    = st_q.fcfg;
    assign nd_o      = st_q.nd;
    assign win_o     = st_q.win;
    assign mat_o     = st_q.mat;
    assign epos_o    = st_q.epos;
    assign eneg_o    = st_q.eneg;
    assign pdown_o   = st_q.pdown;
    assign irq_o     = st_q.irq;

    // R6: divider always in 1..64
    a_r6_pll_range: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_o >= 7'd1) && (pll_o <= 7'd64));
    // R8: a status write with no event ANDs the value in
    a_r8_and_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == A_IRQ && evt_i == '0)
        |=> irq_o == ($past(irq_o) & $past(wdata_i[GPIO_W-1:0])));
    // R8: an event bit is always set the next cycle
    a_r8_evt_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> (irq_o & $past(evt_i)) == $past(evt_i));
endmodule

// File: rtl/disp_regport.sv
module disp_regport
    import disp_regport_pkg::*;
#(
    parameter int COORD_W     = 10,
    parameter int REF_W       = 12,
    parameter int MAT_N       = 18,
    parameter int GPIO_W      = 8,
    parameter int FILT_DEPTH  = 32,
    parameter int GAMMA_DEPTH = 256,
    localparam int FLW = $clog2(FILT_DEPTH),
    localparam int GLW = $clog2(GAMMA_DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr_i,
    input  logic                  bus_rd_i,
    input  logic                  bus_dc_i,
    input  logic [15:0]           bus_wdata_i,
    output logic [15:0]           bus_rdata_o,
    input  logic [GPIO_W-1:0]     gpio_evt_i,
    input  logic [FLW-1:0]        filt_lu_addr_i,
    output logic [7:0]            filt_lu_data_o,
    input  logic [GLW-1:0]        gamma_lu_addr_i,
    output logic [7:0]            gamma_lu_data_o,
    output logic [6:0]            pll_div_o,
    output logic [REF_W-1:0]      refresh_o,
    output logic [7:0]            lcd_cfg_o,
    output logic [7:0]            tx_mode_o,
    output logic [7:0]            filt_cfg_o,
    output logic [7:0]            nd_ctrl_o,
    output logic [COORD_W-1:0]    win_x0_o,
    output logic [COORD_W-1:0]    win_y0_o,
    output logic [COORD_W-1:0]    win_x1_o,
    output logic [COORD_W-1:0]    win_y1_o,
    output logic [MAT_N*8-1:0]    matrix_coeff_o,
    output logic [GPIO_W-1:0]     gpio_pos_en_o,
    output logic [GPIO_W-1:0]     gpio_neg_en_o,
    output logic [GPIO_W-1:0]     gpio_pdown_o,
    output logic [GPIO_W-1:0]     gpio_irq_o,
    output logic                  pix_wr_o,
    output logic [15:0]           pix_data_o
);
    localparam int N_WIN = 4;
    localparam int FIW = FLW + 1;
    localparam int GIW = GLW;

    addr_t              addr;
    logic               data_wr, data_rd;
    logic [BUS_W-1:0]   rd_val, cfg_rd;
    logic [FIW-1:0]     filt_idx;
    logic [GIW-1:0]     gam_idx;
    logic [7:0]         filt_rd, gam_rd;
    logic [N_WIN-1:0][COORD_W-1:0] win;
    logic [MAT_N-1:0][7:0] mat;

    disp_regport_bus u_bus (
        .clk(clk), .rst_n(rst_n), .wr_i(bus_wr_i), .rd_i(bus_rd_i),
        .dc_i(bus_dc_i), .wdata_i(bus_wdata_i[7:0]), .rd_val_i(rd_val),
        .addr_o(addr), .data_wr_o(data_wr), .data_rd_o(data_rd),
        .rdata_o(bus_rdata_o));

    disp_regport_cfg #(
        .COORD_W(COORD_W), .REF_W(REF_W), .MAT_N(MAT_N),
        .N_WIN(N_WIN), .GPIO_W(GPIO_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_i(data_wr), .addr_i(addr),
        .wdata_i(bus_wdata_i[7:0]), .evt_i(gpio_evt_i), .rd_val_o(cfg_rd),
        .pll_o(pll_div_o), .refresh_o(refresh_o), .lcd_o(lcd_cfg_o),
        .txm_o(tx_mode_o), .fcfg_o(filt_cfg_o), .nd_o(nd_ctrl_o),
        .win_o(win), .mat_o(mat), .epos_o(gpio_pos_en_o),
        .eneg_o(gpio_neg_en_o), .pdown_o(gpio_pdown_o), .irq_o(gpio_irq_o));

    disp_regport_table #(.DEPTH(FILT_DEPTH), .SATURATE(1'b1)) u_filt (
        .clk(clk), .rst_n(rst_n),
        .idx_wr_i(data_wr && addr == A_FIDX),
        .idx_val_i(FIW'(bus_wdata_i[FLW-1:0])),
        .acc_wr_i(data_wr && addr == A_FDATA),
        .acc_rd_i(data_rd && addr == A_FDATA),
        .wdata_i(bus_wdata_i[7:0]), .idx_o(filt_idx), .rdata_o(filt_rd),
        .lu_addr_i(filt_lu_addr_i), .lu_data_o(filt_lu_data_o));

    disp_regport_table #(.DEPTH(GAMMA_DEPTH), .SATURATE(1'b0)) u_gamma (
        .clk(clk), .rst_n(rst_n),
        .idx_wr_i(data_wr && addr == A_GIDX),
        .idx_val_i(bus_wdata_i[GLW-1:0]),
        .acc_wr_i(data_wr && addr == A_GDATA),
        .acc_rd_i(data_rd && addr == A_GDATA),
        .wdata_i(bus_wdata_i[7:0]), .idx_o(gam_idx), .rdata_o(gam_rd),
        .lu_addr_i(gamma_lu_addr_i), .lu_data_o(gamma_lu_data_o));

    always_comb begin
        case (addr)
            A_FIDX:  rd_val = BUS_W'(filt_idx);
            A_FDATA: rd_val = BUS_W'(filt_rd);
            A_GIDX:  rd_val = BUS_W'(gam_idx);
            A_GDATA: rd_val = BUS_W'(gam_rd);
            default: rd_val = cfg_rd;
        endcase
    end

    assign win_x0_o       = win[0];
    assign win_y0_o       = win[1];
    assign win_x1_o       = win[2];
    assign win_y1_o       = win[3];
    assign matrix_coeff_o = mat;
    assign pix_wr_o       = data_wr && (addr == A_PIXEL);
    assign pix_data_o     = bus_wdata_i;

    // R12: pixel strobe only with a data write at the pixel port
    a_r12_pix_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        pix_wr_o |-> (bus_wr_i && bus_dc_i));
endmodule

// File: tb/disp_regport_tb_top.sv
`timescale 1ns/1ps
module disp_regport_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr_i = 1'b0, bus_rd_i = 1'b0, bus_dc_i = 1'b0;
    logic [15:0] bus_wdata_i = '0;
    logic [15:0] bus_rdata_o;
    logic [7:0]  gpio_evt_i = '0;
    logic [4:0]  filt_lu_addr_i = '0;
    logic [7:0]  filt_lu_data_o;
    logic [7:0]  gamma_lu_addr_i = '0;
    logic [7:0]  gamma_lu_data_o;
    logic [6:0]  pll_div_o;
    logic [11:0] refresh_o;
    logic [7:0]  lcd_cfg_o, tx_mode_o, filt_cfg_o, nd_ctrl_o;
    logic [9:0]  win_x0_o, win_y0_o, win_x1_o, win_y1_o;
    logic [143:0] matrix_coeff_o;
    logic [7:0]  gpio_pos_en_o, gpio_neg_en_o, gpio_pdown_o, gpio_irq_o;
    logic        pix_wr_o;
    logic [15:0] pix_data_o;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    disp_regport dut_i (.*);

    localparam int OP_CMD = 0, OP_WR = 1, OP_RD = 2, OP_CRD = 3;

    typedef struct packed {
        logic [1:0]  op;
        logic [15:0] data;
        logic [15:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 41;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 16'h0002, 16'h0000, 8'd0},  '{2'd2, 16'h0, 16'h0083, 8'd10}, // R10
        '{2'd0, 16'h0004, 16'h0000, 8'd0},  '{2'd2, 16'h0, 16'h0080, 8'd6},  // R6 reset
        '{2'd0, 16'h0004, 16'h0000, 8'd0},  '{2'd1, 16'h00C5, 16'h0, 8'd0},
        '{2'd0, 16'h0004, 16'h0000, 8'd0},  '{2'd2, 16'h0, 16'h0085, 8'd6},  // R6
        '{2'd0, 16'h0018, 16'h0000, 8'd0},  '{2'd2, 16'h0, 16'h005C, 8'd7},  // R7
        '{2'd2, 16'h0, 16'h0002, 8'd2},                                        // R2 advance
        '{2'd0, 16'h0028, 16'h0000, 8'd0},  '{2'd2, 16'h0, 16'h0074, 8'd11}, // R11
        '{2'd0, 16'h0042, 16'h0000, 8'd0},  '{2'd1, 16'h00FF, 16'h0, 8'd0},
        '{2'd0, 16'h0042, 16'h0000, 8'd0},  '{2'd2, 16'h0, 16'h00BD, 8'd11}, // R11 mask
        '{2'd0, 16'h0056, 16'h0000, 8'd0},  '{2'd2, 16'h0, 16'h0080, 8'd11},
        '{2'd0, 16'h00F8, 16'h0000, 8'd0},  '{2'd2, 16'h0, 16'h00FF, 8'd11},
        '{2'd0, 16'h00E8, 16'h0000, 8'd0},  '{2'd1, 16'h00FF, 16'h0, 8'd0},
        '{2'd0, 16'h00E8, 16'h0000, 8'd0},  '{2'd2, 16'h0, 16'h003B, 8'd10}, // R10
        '{2'd0, 16'h006C, 16'h0000, 8'd0},  '{2'd1, 16'h00AB, 16'h0, 8'd0},
        '{2'd1, 16'h00FF, 16'h0000, 8'd0},
        '{2'd0, 16'h006C, 16'h0000, 8'd0},  '{2'd2, 16'h0, 16'h00AB, 8'd7},  // R7
        '{2'd2, 16'h0, 16'h0003, 8'd7},
        '{2'd0, 16'h00BC, 16'h0000, 8'd0},  '{2'd1, 16'h00FF, 16'h0, 8'd0},
        '{2'd1, 16'h00FF, 16'h0000, 8'd0},
        '{2'd0, 16'h00BC, 16'h0000, 8'd0},  '{2'd2, 16'h0, 16'h00FF, 8'd9},  // R9
        '{2'd2, 16'h0, 16'h0080, 8'd9},
        '{2'd0, 16'h0040, 16'h0000, 8'd0},  '{2'd1, 16'h1234, 16'h0, 8'd0},
        '{2'd0, 16'h0040, 16'h0000, 8'd0},  '{2'd2, 16'h0, 16'h0000, 8'd3}   // R3 unmapped
    };

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic op(int kind, logic [15:0] d);
        @(negedge clk);
        bus_dc_i    = (kind == OP_WR) || (kind == OP_RD);
        bus_wr_i    = (kind == OP_CMD) || (kind == OP_WR);
        bus_rd_i    = (kind == OP_RD) || (kind == OP_CRD);
        bus_wdata_i = d;
        @(negedge clk);
        bus_wr_i = 1'b0;
        bus_rd_i = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R11 and R7 reset values at the ports
        chk("R7 refresh reset", 32'(refresh_o), 32'h25C);
        chk("R11 lcd reset", 32'(lcd_cfg_o), 32'h74);
        chk("R11 pulldown reset", 32'(gpio_pdown_o), 32'hFF);
        chk("R11 matrix reset", 32'(|matrix_coeff_o), 32'h0);
        chk("R11 edge reset", 32'({gpio_pos_en_o, gpio_neg_en_o, gpio_irq_o}), 32'h0);
        chk("R6 divider reset", 32'(pll_div_o), 32'h1);

        for (int i = 0; i < NV; i++) begin
            op(int'(VECS[i].op), VECS[i].data);
            if (VECS[i].op == 2'(OP_RD))
                chk($sformatf("R%0d vector %0d", VECS[i].req, i),
                    32'(bus_rdata_o), 32'(VECS[i].exp));
        end
        chk("R6 divider out", 32'(pll_div_o), 32'h6);
        chk("R7 window x0", 32'(win_x0_o), 32'h3AB);
        chk("R9 matrix out", 32'(matrix_coeff_o[15:0]), 32'h80FF);
        chk("R11 tx mode mask", 32'(tx_mode_o), 32'hBD);

        // R1: command load and command read-back
        op(OP_CMD, 16'h1234);
        op(OP_CRD, 16'h0);
        chk("R1 cmd readback", 32'(bus_rdata_o), 32'h0034);

        // R4: filter table, index saturates at 32
        op(OP_CMD, 16'h0058); op(OP_WR, 16'h003E);
        op(OP_CMD, 16'h005A);
        op(OP_WR, 16'h0011); op(OP_WR, 16'h0022); op(OP_WR, 16'h0033);
        op(OP_CRD, 16'h0);
        chk("R2 filter port holds", 32'(bus_rdata_o), 32'h005A);
        op(OP_CMD, 16'h0058); op(OP_RD, 16'h0);
        chk("R4 index at end", 32'(bus_rdata_o), 32'h0020);
        op(OP_CMD, 16'h005A); op(OP_RD, 16'h0);
        chk("R4 read past end", 32'(bus_rdata_o), 32'h0000);
        op(OP_CMD, 16'h0058); op(OP_WR, 16'h001E);
        op(OP_CMD, 16'h005A);
        op(OP_RD, 16'h0); chk("R4 entry 30", 32'(bus_rdata_o), 32'h11);
        op(OP_RD, 16'h0); chk("R4 entry 31", 32'(bus_rdata_o), 32'h22);
        filt_lu_addr_i = 5'd0; #1;
        chk("R4 ignored write", 32'(filt_lu_data_o), 32'h0);

        // R5: gamma table wraps
        op(OP_CMD, 16'h00B6); op(OP_WR, 16'h00FF);
        op(OP_CMD, 16'h00B8); op(OP_WR, 16'h000A); op(OP_WR, 16'h000B);
        gamma_lu_addr_i = 8'hFF; #1;
        chk("R5 gamma 255", 32'(gamma_lu_data_o), 32'h0A);
        gamma_lu_addr_i = 8'h00; #1;
        chk("R5 gamma wrap", 32'(gamma_lu_data_o), 32'h0B);
        op(OP_CMD, 16'h00B6); op(OP_RD, 16'h0);
        chk("R5 gamma index", 32'(bus_rdata_o), 32'h01);

        // R8: interrupt status set and clear
        @(negedge clk); gpio_evt_i = 8'hF0;
        @(negedge clk); gpio_evt_i = 8'h00;
        chk("R8 event set", 32'(gpio_irq_o), 32'hF0);
        op(OP_CMD, 16'h00F6); op(OP_WR, 16'h0030);
        chk("R8 and clear", 32'(gpio_irq_o), 32'h30);
        op(OP_CMD, 16'h00F6);
        @(negedge clk);
        bus_dc_i = 1'b1; bus_wr_i = 1'b1; bus_wdata_i = 16'h0000; gpio_evt_i = 8'h01;
        @(negedge clk);
        bus_wr_i = 1'b0; gpio_evt_i = 8'h00;
        chk("R8 set wins", 32'(gpio_irq_o), 32'h01);

        // R12: pixel port strobe and stream hold
        op(OP_CMD, 16'h0090);
        @(negedge clk);
        bus_dc_i = 1'b1; bus_wr_i = 1'b1; bus_wdata_i = 16'hBEEF;
        #1;
        chk("R12 pixel strobe", 32'(pix_wr_o), 32'h1);
        chk("R12 pixel data", 32'(pix_data_o), 32'hBEEF);
        @(negedge clk);
        bus_wr_i = 1'b0;
        #1;
        chk("R12 strobe ends", 32'(pix_wr_o), 32'h0);
        op(OP_RD, 16'h0);
        chk("R12 pixel read", 32'(bus_rdata_o), 32'h0);
        op(OP_CRD, 16'h0);
        chk("R2 pixel port holds", 32'(bus_rdata_o), 32'h0090);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule